// File: doc/BRIEF.md
# Transceiver TX Reset Sequencer

This block generates the reset outputs for a multi-channel serial transmitter. It takes one active-high reset request and the raw lock indication of the transmit PLL. It produces a PLL powerdown output, a filtered lock status, and one digital reset and one ready flag per channel. The powerdown output is held for a fixed time after reset. The lock indication must stay high for a set time before it counts as locked. Each channel's digital reset is released only after every gating condition has cleared and a hold time has passed.

All durations are compile-time parameters in nanoseconds. At elaboration each one becomes a number of clock cycles, equal to ceil(ns × CLK_MHZ / 1000). The powerdown and hold times are clamped to at least one cycle. The reset input is synchronised to the clock by default, and this can be turned off. A parameter chooses between an independent sequencer for each channel and one sequencer shared by all channels.

A run-time mode bit for each channel decides what happens when lock is lost after release. In automatic mode the digital reset is asserted again. In manual mode it stays released and recovery is left to the user. All pins are plain control and status signals, so the block has no data stream and no back-pressure.

Top module: `tx_rst_seq`

## Requirements
- R1: `pll_pd_out` is high while the internal reset is active. It stays high for exactly PD_CYC = ceil(PD_NS×CLK_MHZ/1000) further clock edges after the internal reset releases, then goes low.
- R2: With SYNC_RST=1, raising `rst_in` activates the internal reset at once, and releasing it takes effect after two clock edges. With SYNC_RST=0, `rst_in` is used directly.
- R3: `lock_ok` rises only after `pll_lock_in` has been sampled high on HYST_CYC consecutive edges. It is low whenever `pll_lock_in` is low. With HYST_CYC=0 it follows `pll_lock_in` directly. The lock filter is cleared during internal reset.
- R4: Each `tx_dig_rst` bit is high during internal reset and during powerdown. It falls on the DIG_CYC-th consecutive edge at which powerdown is inactive and `lock_ok` is high.
- R5: When `manual_mode` bit = 0 (automatic), a released channel whose `lock_ok` is low at a clock edge reasserts `tx_dig_rst` at that edge and restarts its hold count.
- R6: When `manual_mode` bit = 1 (manual), a released channel keeps `tx_dig_rst` low when lock is lost.
- R7: `tx_ready` bit is high exactly when that channel's digital reset is released and `lock_ok` is high. It drops at once when `rst_in` rises.
- R8: With PER_CH=0, one sequencer drives every channel identically, and only `manual_mode[0]` selects its mode.
- R9: With PLL_EN=0, `pll_pd_out` stays low and powerdown does not gate the digital reset. With TX_EN=0, all `tx_dig_rst` and `tx_ready` bits stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_in | input | 1 | Reset request, active high, asynchronous assertion |
| pll_lock_in | input | 1 | Raw PLL lock indication |
| manual_mode | input | NUM_CH | Per-channel mode, 1 = manual, 0 = automatic |
| pll_pd_out | output | 1 | PLL powerdown |
| lock_ok | output | 1 | Hysteresis-filtered lock |
| tx_dig_rst | output | NUM_CH | Per-channel digital reset |
| tx_ready | output | NUM_CH | Per-channel ready status |

## Verification
The bench sweeps the moment lock arrives across the whole powerdown window. This exposes a hold counter that starts before powerdown ends, which would release too early, and one that never restarts when lock comes late. It sweeps lock pulse lengths around the hysteresis threshold, where an off-by-one filter would accept a pulse one cycle too short or reject one of exactly the threshold length. It drops lock on an automatic channel and a manual channel side by side: a swapped mode decode would reassert the manual channel or leave the automatic one released. Shared-sequencer, bypassed-synchroniser and disabled-control variants run on the same stimulus, so a latency or gating mistake in any variant shows as a shifted release edge or a stray active output.

// File: rtl/tx_rst_pkg.sv
package tx_rst_pkg;
  // Nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned mhz);
    longint unsigned p;
    p = ns * mhz + 64'd999;
    return int'(p / 64'd1000);
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_s
);
  generate
    if (ENABLE) begin : g_sync
      logic [1:0] chain;
      always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) chain <= 2'b11;
        else        chain <= {chain[0], 1'b0};
      end
      assign rst_s = chain[1];
    end else begin : g_direct
      assign rst_s = rst_in;
    end
  endgenerate
endmodule

// File: rtl/tx_lock_filter.sv
module tx_lock_filter #(
  parameter int unsigned HYST_CYC = 4
) (
  input  logic clk,
  input  logic rst_s,
  input  logic lock_raw,
  output logic lock_f
);
  generate
    if (HYST_CYC == 0) begin : g_pass
      assign lock_f = lock_raw;
    end else begin : g_hyst
      localparam int CW = $clog2(HYST_CYC + 1);
      localparam logic [CW-1:0] TOP = CW'(HYST_CYC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s)               cnt <= '0;
        else if (!lock_raw)      cnt <= '0;
        else if (cnt != TOP)     cnt <= cnt + 1'b1;
      end
      assign lock_f = lock_raw && (cnt == TOP);
    end
  endgenerate
endmodule

// File: rtl/tx_dig_chan.sv
module tx_dig_chan #(
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_s,
  input  logic pd_active,
  input  logic lock_f,
  input  logic manual,
  output logic dig_rst
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;
  logic          held;
  logic          gated;

  assign gated = pd_active || !lock_f;

  always_ff @(posedge clk or posedge rst_s) begin
    if (rst_s) begin
      held <= 1'b1;
      cnt  <= '0;
    end else if (held) begin
      if (gated)             cnt <= '0;
      else if (cnt == LAST)  held <= 1'b0;
      else                   cnt <= cnt + 1'b1;
    end else if (!lock_f && !manual) begin
      held <= 1'b1;
      cnt  <= '0;
    end
  end

  assign dig_rst = held;
endmodule

// File: rtl/tx_rst_seq.sv
module tx_rst_seq #(
  parameter int          NUM_CH   = 2,
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned PD_NS    = 1000,
  parameter int unsigned DIG_NS   = 20,
  parameter int unsigned HYST_NS  = 40,
  parameter bit          SYNC_RST = 1'b1,
  parameter bit          PER_CH   = 1'b1,
  parameter bit          PLL_EN   = 1'b1,
  parameter bit          TX_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              pll_lock_in,
  input  logic [NUM_CH-1:0] manual_mode,
  output logic              pll_pd_out,
  output logic              lock_ok,
  output logic [NUM_CH-1:0] tx_dig_rst,
  output logic [NUM_CH-1:0] tx_ready
);
  import tx_rst_pkg::*;

  localparam int unsigned PD_CYC   = at_least_one(ns_to_cyc(PD_NS, CLK_MHZ));
  localparam int unsigned DIG_CYC  = at_least_one(ns_to_cyc(DIG_NS, CLK_MHZ));
  localparam int unsigned HYST_CYC = ns_to_cyc(HYST_NS, CLK_MHZ);
  localparam int          NSEQ     = PER_CH ? NUM_CH : 1;

  logic rst_s;
  logic pd_active;
  logic lock_f;
  logic [NSEQ-1:0] seq_rst;

  tx_rst_sync #(.ENABLE(SYNC_RST)) u_sync (
    .clk(clk), .rst_in(rst_in), .rst_s(rst_s)
  );

  tx_lock_filter #(.HYST_CYC(HYST_CYC)) u_filt (
    .clk(clk), .rst_s(rst_s), .lock_raw(pll_lock_in), .lock_f(lock_f)
  );

  generate
    if (PLL_EN) begin : g_pd
      localparam int PW = $clog2(PD_CYC + 1);
      logic [PW-1:0] pd_cnt;
      always_ff @(posedge clk or posedge rst_s) begin
        if (rst_s)              pd_cnt <= PW'(PD_CYC);
        else if (pd_cnt != '0)  pd_cnt <= pd_cnt - 1'b1;
      end
      assign pd_active = rst_s || (pd_cnt != '0);
    end else begin : g_no_pd
      assign pd_active = 1'b0;
    end

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
      tx_dig_chan #(.HOLD_CYC(DIG_CYC)) u_chan (
        .clk(clk), .rst_s(rst_s), .pd_active(pd_active), .lock_f(lock_f),
        .manual(manual_mode[s]), .dig_rst(seq_rst[s])
      );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      localparam int SRC = PER_CH ? c : 0;
      if (TX_EN) begin : g_on
        assign tx_dig_rst[c] = seq_rst[SRC];
        assign tx_ready[c]   = !seq_rst[SRC] && lock_f && !rst_s;
      end else begin : g_off
        assign tx_dig_rst[c] = 1'b0;
        assign tx_ready[c]   = 1'b0;
      end
    end
  endgenerate

  assign pll_pd_out = pd_active;
  assign lock_ok    = lock_f;
endmodule

// File: rtl/tx_rst_seq_chk.sv
module tx_rst_seq_chk #(
  parameter int          NUM_CH   = 2,
  parameter bit          PER_CH   = 1'b1,
  parameter bit          TX_EN    = 1'b1,
  parameter int unsigned HYST_CYC = 4
) (
  input logic              clk,
  input logic              rst_in,
  input logic              pll_lock_in,
  input logic [NUM_CH-1:0] manual_mode,
  input logic              pll_pd_out,
  input logic              lock_ok,
  input logic [NUM_CH-1:0] tx_dig_rst,
  input logic [NUM_CH-1:0] tx_ready
);
  // R3
  lock_needs_raw_chk: assert property (@(posedge clk) disable iff (rst_in)
    !pll_lock_in |-> !lock_ok);

  generate
    if (HYST_CYC > 0) begin : g_hyst
      // R3
      lock_rise_after_raw_chk: assert property (@(posedge clk) disable iff (rst_in)
        $rose(lock_ok) |-> $past(pll_lock_in));
    end

    if (TX_EN) begin : g_tx
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int SEL = PER_CH ? i : 0;
        // R4
        pd_holds_dig_chk: assert property (@(posedge clk) disable iff (rst_in)
          pll_pd_out |-> tx_dig_rst[i]);
        // R4
        release_after_clear_chk: assert property (@(posedge clk) disable iff (rst_in)
          $fell(tx_dig_rst[i]) |-> ($past(lock_ok) && !$past(pll_pd_out)));
        // R5
        auto_rearm_chk: assert property (@(posedge clk) disable iff (rst_in)
          (!tx_dig_rst[i] && !manual_mode[SEL] && !lock_ok) |=> tx_dig_rst[i]);
        // R6
        manual_keep_chk: assert property (@(posedge clk) disable iff (rst_in)
          (!tx_dig_rst[i] && manual_mode[SEL]) |=> !tx_dig_rst[i]);
        // R7
        ready_lock_chk: assert property (@(posedge clk) disable iff (rst_in)
          $rose(tx_ready[i]) |-> (lock_ok && !tx_dig_rst[i]));
      end
    end else begin : g_notx
      // R9
      tx_off_chk: assert property (@(posedge clk)
        (tx_dig_rst == '0) && (tx_ready == '0));
    end
  endgenerate
endmodule

bind tx_rst_seq tx_rst_seq_chk #(
  .NUM_CH(NUM_CH), .PER_CH(PER_CH), .TX_EN(TX_EN), .HYST_CYC(HYST_CYC)
) u_chk (
  .clk(clk), .rst_in(rst_in), .pll_lock_in(pll_lock_in),
  .manual_mode(manual_mode), .pll_pd_out(pll_pd_out), .lock_ok(lock_ok),
  .tx_dig_rst(tx_dig_rst), .tx_ready(tx_ready)
);

// File: tb/sim_tx_rst_seq.sv
module sim_tx_rst_seq;
  localparam int CLK_T = 10;
  localparam int SYNC_LAT = 2;
  localparam int PD_C = 5;   // ceil(45 ns * 100 MHz / 1000)
  localparam int DIG_C = 3;  // ceil(25 ns * 100 MHz / 1000)
  localparam int HYS_C = 4;  // 40 ns at 100 MHz

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic lock = 1'b0;
  logic [1:0] mode = 2'b10;

  logic pd0, lk0, pd1, lk1, pd2, lk2;
  logic [1:0] dg0, rd0, dg1, rd1, dg2, rd2;

  int checks = 0;
  int errors = 0;
  bit u2_bad = 1'b0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  tx_rst_seq #(.NUM_CH(2), .CLK_MHZ(100), .PD_NS(45), .DIG_NS(25), .HYST_NS(40),
    .SYNC_RST(1), .PER_CH(1), .PLL_EN(1), .TX_EN(1)) u0 (
    .clk(clk), .rst_in(rst_in), .pll_lock_in(lock), .manual_mode(mode),
    .pll_pd_out(pd0), .lock_ok(lk0), .tx_dig_rst(dg0), .tx_ready(rd0));

  tx_rst_seq #(.NUM_CH(2), .CLK_MHZ(100), .PD_NS(45), .DIG_NS(25), .HYST_NS(0),
    .SYNC_RST(0), .PER_CH(0), .PLL_EN(0), .TX_EN(1)) u1 (
    .clk(clk), .rst_in(rst_in), .pll_lock_in(lock), .manual_mode(mode),
    .pll_pd_out(pd1), .lock_ok(lk1), .tx_dig_rst(dg1), .tx_ready(rd1));

  tx_rst_seq #(.NUM_CH(2), .CLK_MHZ(100), .PD_NS(45), .DIG_NS(25), .HYST_NS(40),
    .SYNC_RST(1), .PER_CH(1), .PLL_EN(1), .TX_EN(0)) u2 (
    .clk(clk), .rst_in(rst_in), .pll_lock_in(lock), .manual_mode(mode),
    .pll_pd_out(pd2), .lock_ok(lk2), .tx_dig_rst(dg2), .tx_ready(rd2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Leave at the falling edge after the next rising edge
  task automatic tick();
    @(posedge clk);
    #(CLK_T/2);
    if (dg2 != 2'b00 || rd2 != 2'b00) u2_bad = 1'b1;
  endtask

  initial begin
    #(CLK_T * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g0;
    int s;
    bit seen;
    for (int i = 0; i < 4; i++) tick();
    // Reset state
    chk(pd0 == 1'b1, "R1 pd in reset", pd0, 1);
    chk(dg0 == 2'b11, "R4 dig in reset", dg0, 3);
    chk(rd0 == 2'b00, "R7 ready in reset", rd0, 0);
    chk(lk0 == 1'b0, "R3 lock_ok in reset", lk0, 0);
    chk(pd1 == 1'b0, "R9 pd disabled", pd1, 0);

    // Sweep lock arrival edge L across the powerdown window
    for (int L = 1; L <= 8; L++) begin
      rst_in = 1'b1;
      lock = 1'b0;
      tick(); tick();
      rst_in = 1'b0;
      s = (L > SYNC_LAT + 1) ? L : SYNC_LAT + 1;
      g0 = s + HYS_C - 1;
      if (g0 < SYNC_LAT + PD_C) g0 = SYNC_LAT + PD_C;
      for (int k = 1; k <= 14; k++) begin
        if (k == L) lock = 1'b1;
        tick();
        if (k == SYNC_LAT + PD_C - 1) begin
          chk(pd0 == 1'b1, "R1 pd still high", pd0, 1);
          chk(pd2 == 1'b1, "R1 pd still high u2", pd2, 1);
        end
        if (k == SYNC_LAT + PD_C) begin
          chk(pd0 == 1'b0, "R1 R2 pd released", pd0, 0);
          chk(pd2 == 1'b0, "R1 pd released u2", pd2, 0);
        end
        if (k == s + HYS_C - 2) chk(lk0 == 1'b0, "R3 lock_ok early", lk0, 0);
        if (k == s + HYS_C - 1) chk(lk0 == 1'b1, "R3 lock_ok on time", lk0, 1);
        if (k == g0 + DIG_C - 1) chk(dg0 == 2'b11, "R4 dig held", dg0, 3);
        if (k == g0 + DIG_C) begin
          chk(dg0 == 2'b00, "R4 dig released", dg0, 0);
          chk(rd0 == 2'b11, "R7 ready", rd0, 3);
        end
        if (k == L + DIG_C - 2) chk(dg1 == 2'b11, "R8 R9 shared held", dg1, 3);
        if (k == L + DIG_C - 1) chk(dg1 == 2'b00 && rd1 == 2'b11,
                                    "R8 R9 shared released", dg1, 0);
        chk(pd1 == 1'b0, "R9 pd stays low", pd1, 0);
      end
    end

    // Hysteresis pulse sweep with ch0 automatic, ch1 manual
    mode = 2'b10;
    for (int h = 1; h <= 7; h++) begin
      lock = 1'b0;
      tick();
      chk(dg0[0] == 1'b1, "R5 auto rearm", dg0[0], 1);
      chk(dg0[1] == 1'b0, "R6 manual keeps released", dg0[1], 0);
      chk(rd0 == 2'b00, "R7 ready drops on lock loss", rd0, 0);
      chk(dg1 == 2'b11, "R8 shared auto rearm", dg1, 3);
      lock = 1'b1;
      seen = 1'b0;
      for (int j = 1; j <= h; j++) begin
        tick();
        seen |= lk0;
      end
      chk(seen == (h >= HYS_C), "R3 pulse filter", seen, int'(h >= HYS_C));
    end
    lock = 1'b0;
    tick();
    lock = 1'b1;
    for (int k = 1; k <= HYS_C + DIG_C; k++) begin
      tick();
      if (k == HYS_C + DIG_C - 1) chk(dg0[0] == 1'b1, "R5 hold restarted", dg0[0], 1);
    end
    chk(dg0 == 2'b00 && rd0 == 2'b11, "R5 R6 recovered", dg0, 0);
    chk(dg1 == 2'b00, "R8 shared recovered", dg1, 0);

    // Asynchronous reset entry
    rst_in = 1'b1;
    #1;
    chk(rd0 == 2'b00 && rd1 == 2'b00, "R7 ready drops on reset", rd0, 0);
    chk(dg0 == 2'b11 && dg1 == 2'b11, "R2 immediate reset", dg0, 3);
    chk(pd0 == 1'b1, "R1 R2 pd on reset", pd0, 1);
    tick();
    chk(!u2_bad, "R9 tx disabled outputs", u2_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule